// File: doc/BRIEF.md
# Core Wake and Access Handshake Controller

This block manages the power state of a device's internal core on behalf of a host. The host sees one general-purpose control word. In it the host sets an access request to wake the core and keep it awake, and an init-done bit that moves the device into full operating mode. The block reports in the same word when the core clock is ready and when the core is about to enter power-down. A 3-bit field gives the current power-save type. A separate reset word carries a soft-reset command that drops the device back to low power.

Inside, a four-state sequencer moves through asleep, waking, awake and going-to-sleep. A down-counter times the wake and sleep delays, and each delay is a parameter. An external sleep hint lets the core start power-down once the host has released its request. A new request made during power-down cancels it. Internal access is granted only while the clock is ready, power-down is not in progress and the host is requesting. This grant is also driven on its own output pin.

Top module: `core_wake_ctrl`

## Requirements
- R1: After reset the control word reads with clock-ready (bit 0), init-done (bit 2), access request (bit 3) and going-to-sleep (bit 4) all 0, the power-save field (bits 26..24) at 001, and access_grant at 0.
- R2: A write with wr_sel=0 loads init-done from wr_data bit 2 and the access request from wr_data bit 3. Both read back at the same bit positions after the write edge.
- R3: Clock-ready never rises while init-done is 0, even when the access request is held at 1. This includes the period after a power-on reset and the period after a soft reset.
- R4: When a control write leaves both init-done and the access request at 1 from the asleep state, clock-ready reads 1 exactly WAKE_CYC+1 clock edges after the write edge, and reads 0 one edge earlier.
- R5: access_grant is 1 exactly when clock-ready is 1, going-to-sleep is 0 and the access request is 1.
- R6: While awake with the request at 0 and sleep_hint at 1, going-to-sleep reads 1 after the next edge, with clock-ready still 1. After SLEEP_CYC further edges, clock-ready and going-to-sleep both read 0.
- R7: Releasing the request while sleep_hint is 0 leaves clock-ready at 1 and going-to-sleep at 0.
- R8: If the access request reads 1 while going-to-sleep is 1, the sleep is aborted. After the next edge going-to-sleep reads 0, clock-ready stays 1 and access is granted.
- R9: The power-save field reads 001 (core powered down) while clock-ready is 0. It reads 010 (radio powered down) while clock-ready is 1 and radio_idle is 1. Otherwise it reads 000.
- R10: A write with wr_sel=1 and wr_data bit 7 set clears init-done and the access request, and clock-ready reads 0 after that same edge. A wr_sel=1 write with bit 7 clear changes nothing.
- R11: Clearing init-done while awake returns the device to low power: clock-ready reads 0 one edge after the write edge.
- R12: Every control-word bit outside 0, 2, 3, 4 and 26..24 reads 0, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the reset word |
| wr_data | input | 32 | Write data |
| sleep_hint | input | 1 | Core signals that it may power down once unrequested |
| radio_idle | input | 1 | Radio section is powered down |
| rd_data | output | 32 | Current control word read value |
| clk_ready | output | 1 | Core clock is ready |
| going_to_sleep | output | 1 | Core is entering power-down |
| access_grant | output | 1 | Host may access internal resources |

## Verification
The assertions check on every cycle the relations between the status bits. The grant must match its three conditions. Going-to-sleep is only seen with clock-ready. Clock-ready never rises without init-done. The power-save field reads 001 whenever the clock is down. A request seen during power-down is followed by an aborted sleep, and a soft reset is followed by a cleared word. Only the bench scenarios can show the exact wake and sleep latencies, that bits written outside the defined fields are dropped, the no-effect reset write, the hint-free release and the return to low power when init-done is cleared.

// File: rtl/wake_ctrl_pkg.sv
package wake_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_ASLEEP = 2'd0,
    ST_WAKING = 2'd1,
    ST_AWAKE  = 2'd2,
    ST_DOZING = 2'd3
  } wake_state_e;

  // Control-word bit positions decoded by host software.
  localparam int BIT_READY = 0;
  localparam int BIT_INIT  = 2;
  localparam int BIT_REQ   = 3;
  localparam int BIT_GTS   = 4;
  localparam int PS_LSB    = 24;
  localparam int PS_W      = 3;
  // Reset-word command bit.
  localparam int BIT_SRST  = 7;

  localparam logic [PS_W-1:0] PS_NONE  = 3'b000;
  localparam logic [PS_W-1:0] PS_CORE  = 3'b001;
  localparam logic [PS_W-1:0] PS_RADIO = 3'b010;

  // Power-save type as seen by the host.
  function automatic logic [PS_W-1:0] ps_code(input logic ready, input logic radio_off);
    if (!ready)         return PS_CORE;
    else if (radio_off) return PS_RADIO;
    else                return PS_NONE;
  endfunction

  // Timer preload so that a phase lasts exactly 'cycles' edges.
  function automatic int unsigned phase_preload(input int unsigned cycles);
    return (cycles == 0) ? 0 : cycles - 1;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wake_ctrl_regs.sv
module wake_ctrl_regs
  import wake_ctrl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              init_done,
  output logic              acc_req,
  output logic              soft_rst
);

  logic ctrl_wr;
  logic rst_wr;

  assign ctrl_wr  = wr_en && !wr_sel;
  assign rst_wr   = wr_en &&  wr_sel;
  assign soft_rst = rst_wr && wr_data[BIT_SRST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_done <= 1'b0;
      acc_req   <= 1'b0;
    end else if (soft_rst) begin
      init_done <= 1'b0;
      acc_req   <= 1'b0;
    end else if (ctrl_wr) begin
      init_done <= wr_data[BIT_INIT];
      acc_req   <= wr_data[BIT_REQ];
    end
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

endmodule

// File: rtl/wake_ctrl_timer.sv
module wake_ctrl_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/wake_ctrl_fsm.sv
module wake_ctrl_fsm
  import wake_ctrl_pkg::*;
#(
  parameter int WAKE_CYC  = 4,
  parameter int SLEEP_CYC = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        init_done,
  input  logic        acc_req,
  input  logic        sleep_hint,
  output wake_state_e state,
  output logic        wake_start,
  output logic        sleep_start,
  output logic        sleep_abort
);

  localparam int unsigned CNT_MAX = max2(WAKE_CYC, SLEEP_CYC);
  localparam int CNT_W = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);
  localparam logic [CNT_W-1:0] WAKE_LD  = CNT_W'(phase_preload(WAKE_CYC));
  localparam logic [CNT_W-1:0] SLEEP_LD = CNT_W'(phase_preload(SLEEP_CYC));

  wake_state_e      state_nxt;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;

  wake_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  assign wake_start  = (state == ST_ASLEEP) && !soft_rst && init_done && acc_req;
  assign sleep_start = (state == ST_AWAKE)  && !soft_rst && init_done && !acc_req && sleep_hint;
  assign sleep_abort = (state == ST_DOZING) && !soft_rst && init_done && acc_req;

  always_comb begin
    state_nxt = state;
    tmr_load  = 1'b0;
    tmr_val   = WAKE_LD;
    if (soft_rst || !init_done) begin
      state_nxt = ST_ASLEEP;
    end else begin
      unique case (state)
        ST_ASLEEP: if (wake_start) begin
          state_nxt = ST_WAKING;
          tmr_load  = 1'b1;
          tmr_val   = WAKE_LD;
        end
        ST_WAKING: begin
          if (!acc_req)         state_nxt = ST_ASLEEP;
          else if (tmr_expired) state_nxt = ST_AWAKE;
        end
        ST_AWAKE: if (sleep_start) begin
          state_nxt = ST_DOZING;
          tmr_load  = 1'b1;
          tmr_val   = SLEEP_LD;
        end
        ST_DOZING: begin
          if (sleep_abort)      state_nxt = ST_AWAKE;
          else if (tmr_expired) state_nxt = ST_ASLEEP;
        end
        default: state_nxt = ST_ASLEEP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_ASLEEP;
    else        state <= state_nxt;
  end

endmodule

// File: rtl/wake_ctrl_status.sv
module wake_ctrl_status
  import wake_ctrl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  wake_state_e       state,
  input  logic              init_done,
  input  logic              acc_req,
  input  logic              radio_idle,
  output logic              ready,
  output logic              gts,
  output logic              grant,
  output logic [PS_W-1:0]   ps_type,
  output logic [DATA_W-1:0] word
);

  assign ready   = (state == ST_AWAKE) || (state == ST_DOZING);
  assign gts     = (state == ST_DOZING);
  assign grant   = ready && !gts && acc_req;
  assign ps_type = ps_code(ready, radio_idle);

  always_comb begin
    word                        = '0;
    word[BIT_READY]             = ready;
    word[BIT_INIT]              = init_done;
    word[BIT_REQ]               = acc_req;
    word[BIT_GTS]               = gts;
    word[PS_LSB +: PS_W]        = ps_type;
  end

endmodule

// File: rtl/core_wake_ctrl.sv
module core_wake_ctrl
  import wake_ctrl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int WAKE_CYC  = 4,
  parameter int SLEEP_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sleep_hint,
  input  logic              radio_idle,
  output logic [DATA_W-1:0] rd_data,
  output logic              clk_ready,
  output logic              going_to_sleep,
  output logic              access_grant
);

  wake_state_e     state;
  logic            init_done;
  logic            acc_req;
  logic            soft_rst;
  logic            wake_start;
  logic            sleep_start;
  logic            sleep_abort;
  logic [PS_W-1:0] ps_type;

  wake_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .init_done (init_done),
    .acc_req   (acc_req),
    .soft_rst  (soft_rst)
  );

  wake_ctrl_fsm #(.WAKE_CYC(WAKE_CYC), .SLEEP_CYC(SLEEP_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .init_done   (init_done),
    .acc_req     (acc_req),
    .sleep_hint  (sleep_hint),
    .state       (state),
    .wake_start  (wake_start),
    .sleep_start (sleep_start),
    .sleep_abort (sleep_abort)
  );

  wake_ctrl_status #(.DATA_W(DATA_W)) u_status (
    .state      (state),
    .init_done  (init_done),
    .acc_req    (acc_req),
    .radio_idle (radio_idle),
    .ready      (clk_ready),
    .gts        (going_to_sleep),
    .grant      (access_grant),
    .ps_type    (ps_type),
    .word       (rd_data)
  );

endmodule

// File: rtl/wake_ctrl_checker.sv
module wake_ctrl_checker
  import wake_ctrl_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            ready,
  input logic            gts,
  input logic            grant,
  input logic            init_done,
  input logic            acc_req,
  input logic            soft_rst,
  input logic            sleep_abort,
  input logic [PS_W-1:0] ps_type
);

  a_r5_grant_cond: assert property (@(posedge clk) disable iff (!rst_n)
    grant == (ready && !gts && acc_req));

  a_r3_ready_needs_init: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> init_done);

  a_r6_gts_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    gts |-> ready);

  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_abort |=> !gts && ready);

  a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !ready && !init_done && !acc_req);

  a_r9_ps_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> ps_type == PS_CORE);

  a_r9_ps_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ps_type));

endmodule

bind core_wake_ctrl wake_ctrl_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ready       (clk_ready),
  .gts         (going_to_sleep),
  .grant       (access_grant),
  .init_done   (init_done),
  .acc_req     (acc_req),
  .soft_rst    (soft_rst),
  .sleep_abort (sleep_abort),
  .ps_type     (ps_type)
);

// File: tb/core_wake_ctrl_tb.sv
module core_wake_ctrl_tb;

  localparam int W = 4;
  localparam int S = 3;

  typedef struct {
    int          cyc;
    logic [31:0] mask;
    logic [31:0] val;
    logic        grant;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        sleep_hint = 1'b0;
  logic        radio_idle = 1'b0;
  logic [31:0] rd_data;
  logic        clk_ready, going_to_sleep, access_grant;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  core_wake_ctrl #(.DATA_W(32), .WAKE_CYC(W), .SLEEP_CYC(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sleep_hint(sleep_hint), .radio_idle(radio_idle), .rd_data(rd_data),
    .clk_ready(clk_ready), .going_to_sleep(going_to_sleep), .access_grant(access_grant)
  );

  task automatic expect_at(input int c, input logic [31:0] m, input logic [31:0] v,
                           input logic g, input string r);
    exp_t e;
    e.cyc = c; e.mask = m; e.val = v; e.grant = g; e.req = r;
    sb.push_back(e);
  endtask

  task automatic reg_write(input logic sel, input logic [31:0] d, output int edge_no);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    edge_no = cyc;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor: compare every expectation due at this cycle.
  always @(negedge clk) begin
    #2;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc <= cyc) begin
        checks++;
        if (sb[i].cyc < cyc ||
            (rd_data & sb[i].mask) != sb[i].val || access_grant != sb[i].grant) begin
          errors++;
          $display("FAIL %s cyc %0d: word %h grant %b, expected %h grant %b (mask %h)",
                   sb[i].req, cyc, rd_data & sb[i].mask, access_grant,
                   sb[i].val, sb[i].grant, sb[i].mask);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int e, f, a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_at(cyc, 32'hFFFF_FFFF, 32'h0100_0000, 1'b0, "R1");

    // R2 / R3: request alone does not wake
    reg_write(1'b0, 32'h8, e);
    expect_at(e, 32'h0000_000C, 32'h8, 1'b0, "R2");
    expect_at(e + W + 3, 32'h0000_001D, 32'h8, 1'b0, "R3");
    wait_to(e + W + 4);

    // R4 / R5 / R9: wake with both bits
    reg_write(1'b0, 32'hC, e);
    a = e + W + 1;
    expect_at(a - 1, 32'h0000_0001, 32'h0, 1'b0, "R4");
    expect_at(a, 32'h0700_001D, 32'h0000_000D, 1'b1, "R4");
    wait_to(a + 1);
    radio_idle = 1'b1;
    expect_at(a + 1, 32'h0700_0001, 32'h0200_0001, 1'b1, "R9");
    @(negedge clk);
    radio_idle = 1'b0;

    // R7: release without hint stays awake
    reg_write(1'b0, 32'h4, e);
    expect_at(e + 3, 32'h0000_001D, 32'h0000_0005, 1'b0, "R7");
    wait_to(e + 4);

    // R6: hint starts power-down
    sleep_hint = 1'b1;
    f = cyc + 1;
    expect_at(f, 32'h0000_0011, 32'h11, 1'b0, "R6");
    expect_at(f + S - 1, 32'h0000_0011, 32'h11, 1'b0, "R6");
    expect_at(f + S, 32'h0700_0011, 32'h0100_0000, 1'b0, "R6");
    wait_to(f + S + 1);

    // R8: abort power-down with a new request
    reg_write(1'b0, 32'hC, e);
    wait_to(e + W + 1);
    reg_write(1'b0, 32'h4, e);
    reg_write(1'b0, 32'hC, f);
    expect_at(f, 32'h0000_001D, 32'h1D, 1'b0, "R8");
    expect_at(f + 1, 32'h0000_001D, 32'h0D, 1'b1, "R8");
    expect_at(f + 4, 32'h0000_001D, 32'h0D, 1'b1, "R8");
    wait_to(f + 5);

    // R11: clearing init-done while awake
    reg_write(1'b0, 32'h8, e);
    expect_at(e, 32'h0000_001D, 32'h09, 1'b1, "R11");
    expect_at(e + 1, 32'h0700_001D, 32'h0100_0008, 1'b0, "R11");
    wait_to(e + 2);

    // R10: reset word, bit 7 clear then set
    sleep_hint = 1'b0;
    reg_write(1'b0, 32'hC, e);
    wait_to(e + W + 1);
    reg_write(1'b1, 32'h7F, e);
    expect_at(e, 32'h0000_001D, 32'h0D, 1'b1, "R10");
    reg_write(1'b1, 32'h80, e);
    expect_at(e, 32'h0700_001D, 32'h0100_0000, 1'b0, "R10");
    wait_to(e + 1);
    reg_write(1'b0, 32'h8, e);
    expect_at(e + W + 2, 32'h0000_0001, 32'h0, 1'b0, "R3");
    wait_to(e + W + 3);

    // R12: undefined bits read zero
    reg_write(1'b0, 32'hFFFF_FFFF, e);
    expect_at(e, 32'hF8FF_FFE2, 32'h0, 1'b0, "R12");
    expect_at(e, 32'h0000_000C, 32'hC, 1'b0, "R2");
    wait_to(e + W + 3);

    repeat (2) @(negedge clk);
    #5;
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule